// File: doc/BRIEF.md
# Byte-Wide Stack Processor Core

This block is a small multi-cycle processor that works on 8-bit data. It holds a 256-byte memory, which stores both the program and the stack, and a file of eight 8-bit registers. The last register, R7, is the stack pointer. The core reads an opcode byte and then zero, one or two operand bytes. It then executes one of six instructions: immediate load, register print, multiply, push, pop and halt. The core stops on a halt instruction or on an opcode it does not recognise. It stays stopped until the next reset.

A program is placed in memory through a byte-wide load port. The port only acts while the synchronous active-low reset is held low. When reset is released, execution starts at address 0 with R7 set to 0xF4. Each print instruction places a register value on the output bus and raises a valid strobe for exactly one cycle. This lets a consumer or a scoreboard collect the program's results.

Top module: `byte_stack_cpu`

## Requirements
- R1: While `rst_n` is low, the core sets its program counter to 0, R0..R6 to 0x00 and R7 to 0xF4, and holds `halted`, `illegal` and `out_valid` low. On every clock edge in that phase with `ld_en` high, `ld_data` is stored at memory address `ld_addr`.
- R2: While `rst_n` is high, the load port has no effect on memory.
- R3: Opcode 0x82 copies its second operand byte into the register selected by the low three bits of its first operand byte.
- R4: Opcode 0x47 drives the selected register onto `out_data`, with `out_valid` high for exactly one cycle.
- R5: Opcode 0xA2 multiplies the register selected by operand one by the register selected by operand two. It writes the low 8 bits of the product back into the first register.
- R6: Opcode 0x45 first decrements R7, then stores the selected register at the new R7 address. When the selected register is R7 itself, the decremented value is stored.
- R7: Opcode 0x46 loads the byte at address R7 into the selected register, then increments R7. When the selected register is R7, R7 ends at the popped byte plus one.
- R8: The operand count of an instruction is its opcode bits [7:6]. An instruction with N operands takes 2+N clock cycles. The program counter then advances by 1+N. All address, PC and stack arithmetic wraps modulo 256.
- R9: Opcode 0x01 raises `halted`, which stays high until reset. No further print output appears after it.
- R10: Any other opcode raises both `halted` and `illegal`, and both stay high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; program loading phase |
| ld_en | input | 1 | Write strobe of the load port (acts only in reset) |
| ld_addr | input | 8 | Memory address for the load port |
| ld_data | input | 8 | Byte written by the load port |
| out_valid | output | 1 | One-cycle strobe for a print result |
| out_data | output | 8 | Printed register value |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Core stopped on an unrecognised opcode |

## Verification
The hardest cases to reach from the ports involve the stack pointer. One is the stack pointer as an ordinary operand, when R7 itself is pushed or popped. The other is the stack pointer wrapping through address 0xFF and back to 0x00. Both can only be set up by programs that first load R7 with a chosen value through an immediate load. Their effect becomes visible only through later print instructions. The bench therefore loads short programs that force R7 to 0x00, 0x40 or 0x80, run push/pop pairs and print both the moved data and R7. A scoreboard compares the printed values in order. Separate programs toggle the load port in mid-run, count cycles up to the halt, and run past halt and illegal opcodes to show that nothing further is printed.

// File: rtl/bsc_pkg.sv
// Shared constants and types of the byte-wide stack processor.
// Assumes byte-sized opcodes; the operand count lives in opcode bits [7:6].
package bsc_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 8;
    localparam int NUM_REGS = 8;
    localparam int RIDX_W   = $clog2(NUM_REGS);

    localparam logic [7:0] OPC_LOADI = 8'h82;
    localparam logic [7:0] OPC_PRINT = 8'h47;
    localparam logic [7:0] OPC_MULT  = 8'hA2;
    localparam logic [7:0] OPC_PUSH  = 8'h45;
    localparam logic [7:0] OPC_POP   = 8'h46;
    localparam logic [7:0] OPC_STOP  = 8'h01;

    localparam logic [DATA_W-1:0] STACK_TOP = 8'hF4;

    typedef enum logic [2:0] {
        K_LOADI, K_PRINT, K_MULT, K_PUSH, K_POP, K_STOP, K_BAD
    } kind_t;

    typedef enum logic [2:0] {
        ST_OPC, ST_OPA, ST_OPB, ST_EXEC, ST_HALT
    } state_t;

    // Number of operand bytes that follow an opcode.
    function automatic logic [1:0] operand_count(input logic [7:0] opc);
        return opc[7:6];
    endfunction

endpackage

// File: rtl/bsc_decode.sv
// Opcode decoder: maps an opcode byte to an instruction kind and its
// operand count. Assumes unknown bytes must be reported as K_BAD.
module bsc_decode
    import bsc_pkg::*;
(
    input  logic [7:0] opc,
    output kind_t      kind,
    output logic [1:0] nops
);

    // Classify the opcode byte.
    always_comb begin
        unique case (opc)
            OPC_LOADI: kind = K_LOADI;
            OPC_PRINT: kind = K_PRINT;
            OPC_MULT:  kind = K_MULT;
            OPC_PUSH:  kind = K_PUSH;
            OPC_POP:   kind = K_POP;
            OPC_STOP:  kind = K_STOP;
            default:   kind = K_BAD;
        endcase
    end

    assign nops = operand_count(opc);

endmodule

// File: rtl/bsc_mem.sv
// Unified program/data memory: asynchronous read, one synchronous write
// port. Assumes the caller muxes loader and stack writes onto that port.
module bsc_mem #(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    // Store a byte when the write port is strobed.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/bsc_regfile.sv
// Register file of NREGS words with two read ports, one general write
// port and a dedicated stack-pointer write port that wins over the
// general port. Assumes the stack pointer is register SP_IDX.
module bsc_regfile #(
    parameter int              DW      = 8,
    parameter int              NREGS   = 8,
    parameter int              RIW     = 3,
    parameter int              SP_IDX  = 7,
    parameter logic [DW-1:0]   SP_INIT = 8'hF4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [RIW-1:0] ra_idx,
    output logic [DW-1:0]  ra_val,
    input  logic [RIW-1:0] rb_idx,
    output logic [DW-1:0]  rb_val,
    input  logic           wr_en,
    input  logic [RIW-1:0] wr_idx,
    input  logic [DW-1:0]  wr_data,
    input  logic           sp_we,
    input  logic [DW-1:0]  sp_data,
    output logic [DW-1:0]  sp_val
);

    logic [DW-1:0] regs [NREGS];

    // Reset every register and apply the stack and general writes.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREGS; i++) begin
            if (!rst_n) begin
                regs[i] <= (i == SP_IDX) ? SP_INIT : '0;
            end else if (sp_we && i == SP_IDX) begin
                regs[i] <= sp_data;
            end else if (wr_en && wr_idx == RIW'(i)) begin
                regs[i] <= wr_data;
            end
        end
    end

    assign ra_val = regs[ra_idx];
    assign rb_val = regs[rb_idx];
    assign sp_val = regs[SP_IDX];

    // The stack pointer moves by exactly one on a stack step without a data write
    AST_SP_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_we && !wr_en && (sp_data == sp_val + DW'(1) || sp_data == sp_val - DW'(1)))
        |=> (sp_val == $past(sp_data)))
        else $error("stack pointer write lost"); // R6

endmodule

// File: rtl/bsc_ctrl.sv
// Sequencer and execution unit: fetches the opcode and operands one byte
// per cycle, executes in one cycle, steps the PC and owns the halt state.
// Assumes an asynchronous-read memory and that AW equals DW for stack
// addressing.
module bsc_ctrl
    import bsc_pkg::*;
#(
    parameter int DW     = 8,
    parameter int AW     = 8,
    parameter int RIW    = 3,
    parameter int SP_IDX = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    output logic [AW-1:0]  mem_raddr,
    input  logic [DW-1:0]  mem_rdata,
    output logic           push_we,
    output logic [AW-1:0]  push_addr,
    output logic [DW-1:0]  push_data,
    output logic [RIW-1:0] ra_idx,
    input  logic [DW-1:0]  ra_val,
    output logic [RIW-1:0] rb_idx,
    input  logic [DW-1:0]  rb_val,
    output logic           rf_we,
    output logic [RIW-1:0] rf_idx,
    output logic [DW-1:0]  rf_data,
    output logic           sp_we,
    output logic [DW-1:0]  sp_data,
    input  logic [DW-1:0]  sp_val,
    output logic           out_valid,
    output logic [DW-1:0]  out_data,
    output logic           halted,
    output logic           illegal
);

    state_t        st_q;
    logic [AW-1:0] pc_q;
    logic [7:0]    opc_q;
    logic [DW-1:0] opa_q;
    logic [DW-1:0] opb_q;
    logic          out_valid_q;
    logic [DW-1:0] out_data_q;
    logic          halted_q;
    logic          illegal_q;

    kind_t         kind;
    logic [1:0]    nops;
    logic [1:0]    new_len;
    logic [DW-1:0] sp_dec;
    logic [DW-1:0] sp_inc;
    logic [2*DW-1:0] product;

    bsc_decode u_decode (
        .opc  (opc_q),
        .kind (kind),
        .nops (nops)
    );

    assign new_len = operand_count(mem_rdata[7:0]);
    assign sp_dec  = sp_val - DW'(1);
    assign sp_inc  = sp_val + DW'(1);
    assign product = ra_val * rb_val;
    assign ra_idx  = opa_q[RIW-1:0];
    assign rb_idx  = opb_q[RIW-1:0];

    // Select the memory read address for the current phase.
    always_comb begin
        unique case (st_q)
            ST_OPC:  mem_raddr = pc_q;
            ST_OPA:  mem_raddr = pc_q + AW'(1);
            ST_OPB:  mem_raddr = pc_q + AW'(2);
            default: mem_raddr = AW'(sp_val);
        endcase
    end

    // Drive register, stack and memory writes of the executing instruction.
    always_comb begin
        rf_we     = 1'b0;
        rf_idx    = ra_idx;
        rf_data   = '0;
        sp_we     = 1'b0;
        sp_data   = sp_val;
        push_we   = 1'b0;
        push_addr = AW'(sp_dec);
        push_data = ra_val;
        if (st_q == ST_EXEC) begin
            unique case (kind)
                K_LOADI: begin
                    rf_we   = 1'b1;
                    rf_data = opb_q;
                end
                K_MULT: begin
                    rf_we   = 1'b1;
                    rf_data = product[DW-1:0];
                end
                K_PUSH: begin
                    sp_we     = 1'b1;
                    sp_data   = sp_dec;
                    push_we   = 1'b1;
                    push_data = (ra_idx == RIW'(SP_IDX)) ? sp_dec : ra_val;
                end
                K_POP: begin
                    sp_we = 1'b1;
                    if (ra_idx == RIW'(SP_IDX)) begin
                        sp_data = mem_rdata + DW'(1);
                    end else begin
                        sp_data = sp_inc;
                        rf_we   = 1'b1;
                        rf_data = mem_rdata;
                    end
                end
                default: ;
            endcase
        end
    end

    // Step through fetch and execute phases and hold the halt state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_OPC;
            pc_q        <= '0;
            opc_q       <= '0;
            opa_q       <= '0;
            opb_q       <= '0;
            out_valid_q <= 1'b0;
            out_data_q  <= '0;
            halted_q    <= 1'b0;
            illegal_q   <= 1'b0;
        end else begin
            out_valid_q <= 1'b0;
            unique case (st_q)
                ST_OPC: begin
                    opc_q <= mem_rdata[7:0];
                    st_q  <= (new_len == 2'd0) ? ST_EXEC : ST_OPA;
                end
                ST_OPA: begin
                    opa_q <= mem_rdata;
                    st_q  <= (nops >= 2'd2) ? ST_OPB : ST_EXEC;
                end
                ST_OPB: begin
                    opb_q <= mem_rdata;
                    st_q  <= ST_EXEC;
                end
                ST_EXEC: begin
                    pc_q <= pc_q + AW'(1) + AW'(nops);
                    unique case (kind)
                        K_PRINT: begin
                            out_valid_q <= 1'b1;
                            out_data_q  <= ra_val;
                            st_q        <= ST_OPC;
                        end
                        K_STOP: begin
                            halted_q <= 1'b1;
                            st_q     <= ST_HALT;
                        end
                        K_BAD: begin
                            halted_q  <= 1'b1;
                            illegal_q <= 1'b1;
                            st_q      <= ST_HALT;
                        end
                        default: st_q <= ST_OPC;
                    endcase
                end
                default: st_q <= ST_HALT;
            endcase
        end
    end

    assign out_valid = out_valid_q;
    assign out_data  = out_data_q;
    assign halted    = halted_q;
    assign illegal   = illegal_q;

    AST_PRINT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_q |=> !out_valid_q)
        else $error("print strobe longer than one cycle"); // R4

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted_q |=> (halted_q && !out_valid_q))
        else $error("halt released or output after halt"); // R9

    AST_ILLEGAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_q |=> (illegal_q && halted_q))
        else $error("illegal flag not sticky"); // R10

    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EXEC && kind != K_STOP && kind != K_BAD)
        |=> (pc_q == $past(pc_q) + AW'(1) + AW'($past(nops))))
        else $error("program counter step wrong"); // R8

endmodule

// File: rtl/byte_stack_cpu.sv
// Top level of the byte-wide stack processor: joins memory, register file
// and sequencer, and gives the load port the memory write path while the
// core is held in reset. Assumes rst_n is synchronous.
module byte_stack_cpu
    import bsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld_en,
    input  logic [7:0] ld_addr,
    input  logic [7:0] ld_data,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       halted,
    output logic       illegal
);

    localparam int SP_IDX = NUM_REGS - 1;

    logic [ADDR_W-1:0] mem_raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata;
    logic              push_we;
    logic [ADDR_W-1:0] push_addr;
    logic [DATA_W-1:0] push_data;
    logic [RIDX_W-1:0] ra_idx;
    logic [RIDX_W-1:0] rb_idx;
    logic [DATA_W-1:0] ra_val;
    logic [DATA_W-1:0] rb_val;
    logic              rf_we;
    logic [RIDX_W-1:0] rf_idx;
    logic [DATA_W-1:0] rf_data;
    logic              sp_we;
    logic [DATA_W-1:0] sp_data;
    logic [DATA_W-1:0] sp_val;

    // Route the loader in reset and the stack pushes when running.
    always_comb begin
        if (!rst_n) begin
            mem_we    = ld_en;
            mem_waddr = ld_addr;
            mem_wdata = ld_data;
        end else begin
            mem_we    = push_we;
            mem_waddr = push_addr;
            mem_wdata = push_data;
        end
    end

    bsc_mem #(
        .DW (DATA_W),
        .AW (ADDR_W)
    ) u_mem (
        .clk   (clk),
        .raddr (mem_raddr),
        .rdata (mem_rdata),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata)
    );

    bsc_regfile #(
        .DW      (DATA_W),
        .NREGS   (NUM_REGS),
        .RIW     (RIDX_W),
        .SP_IDX  (SP_IDX),
        .SP_INIT (STACK_TOP)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_idx  (ra_idx),
        .ra_val  (ra_val),
        .rb_idx  (rb_idx),
        .rb_val  (rb_val),
        .wr_en   (rf_we),
        .wr_idx  (rf_idx),
        .wr_data (rf_data),
        .sp_we   (sp_we),
        .sp_data (sp_data),
        .sp_val  (sp_val)
    );

    bsc_ctrl #(
        .DW     (DATA_W),
        .AW     (ADDR_W),
        .RIW    (RIDX_W),
        .SP_IDX (SP_IDX)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_raddr (mem_raddr),
        .mem_rdata (mem_rdata),
        .push_we   (push_we),
        .push_addr (push_addr),
        .push_data (push_data),
        .ra_idx    (ra_idx),
        .ra_val    (ra_val),
        .rb_idx    (rb_idx),
        .rb_val    (rb_val),
        .rf_we     (rf_we),
        .rf_idx    (rf_idx),
        .rf_data   (rf_data),
        .sp_we     (sp_we),
        .sp_data   (sp_data),
        .sp_val    (sp_val),
        .out_valid (out_valid),
        .out_data  (out_data),
        .halted    (halted),
        .illegal   (illegal)
    );

endmodule

// File: tb/test_byte_stack_cpu.sv
// Scoreboard bench: each test loads a program, queues the expected print
// values, and a negedge monitor compares every strobed output in order.
module test_byte_stack_cpu;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] LDI = 8'h82;
    localparam logic [7:0] PRN = 8'h47;
    localparam logic [7:0] MUL = 8'hA2;
    localparam logic [7:0] PSH = 8'h45;
    localparam logic [7:0] POP = 8'h46;
    localparam logic [7:0] HLT = 8'h01;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_en = 1'b0;
    logic [7:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       halted;
    logic       illegal;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] prog [$];

    byte_stack_cpu i_byte_stack_cpu (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_en     (ld_en),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .out_valid (out_valid),
        .out_data  (out_data),
        .halted    (halted),
        .illegal   (illegal)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_out(input logic [7:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare each strobed print against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected print", int'(out_data), -1);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(out_data == e, t, int'(out_data), int'(e));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic load_prog();
        foreach (prog[i]) begin
            @(negedge clk);
            ld_en   = 1'b1;
            ld_addr = 8'(i);
            ld_data = prog[i];
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic release_core();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_prog(input string tag, input int maxc, input bit exp_ill);
        int n = 0;
        while (!halted && n < maxc) begin
            @(negedge clk);
            n++;
        end
        chk(halted == 1'b1, {tag, " halted"}, int'(halted), 1);
        repeat (20) @(negedge clk);
        chk(halted == 1'b1, {tag, " halt held"}, int'(halted), 1);
        chk(illegal == exp_ill, {tag, " illegal flag"}, int'(illegal), int'(exp_ill));
        chk(exp_q.size() == 0, {tag, " outputs missing"}, exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
        rst_n = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(halted == 1'b0, "R1 halted in reset", int'(halted), 0);
        chk(illegal == 1'b0, "R1 illegal in reset", int'(illegal), 0);
        chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);

        // R1: register reset values seen through prints
        prog = '{PRN, 8'd5, PRN, 8'd7, PRN, 8'd0, HLT};
        load_prog();
        expect_out(8'h00, "R1 R5 reset value");
        expect_out(8'hF4, "R1 R7 reset value");
        expect_out(8'h00, "R1 R0 reset value");
        release_core();
        finish_prog("R1", 100, 1'b0);

        // R3 R4 R8: LDI then PRN, with cycle-exact halt timing (4+3+2 cycles)
        prog = '{LDI, 8'd0, 8'd8, PRN, 8'd0, HLT};
        load_prog();
        expect_out(8'd8, "R3 LDI value printed");
        release_core();
        repeat (8) @(negedge clk);
        chk(halted == 1'b0, "R8 halted before cycle 9", int'(halted), 0);
        @(negedge clk);
        chk(halted == 1'b1, "R8 halted at cycle 9", int'(halted), 1);
        finish_prog("R8", 10, 1'b0);

        // R3: register index uses low three bits of the operand (0x0B -> R3)
        prog = '{LDI, 8'h0B, 8'h3C, PRN, 8'd3, HLT};
        load_prog();
        expect_out(8'h3C, "R3 index low bits");
        release_core();
        finish_prog("R3", 100, 1'b0);

        // R5: products, including truncation to the low byte
        prog = '{LDI, 8'd0, 8'd8, LDI, 8'd1, 8'd9, MUL, 8'd0, 8'd1, PRN, 8'd0,
                 LDI, 8'd2, 8'd20, LDI, 8'd3, 8'd20, MUL, 8'd2, 8'd3, PRN, 8'd2,
                 LDI, 8'd4, 8'h10, MUL, 8'd4, 8'd4, PRN, 8'd4, PRN, 8'd1, HLT};
        load_prog();
        expect_out(8'd72,  "R5 8*9");
        expect_out(8'h90,  "R5 20*20 low byte");
        expect_out(8'h00,  "R5 16*16 low byte");
        expect_out(8'd9,   "R5 source register untouched");
        release_core();
        finish_prog("R5", 200, 1'b0);

        // R6 R7: push/pop round trip and stack pointer return
        prog = '{LDI, 8'd0, 8'd5, PSH, 8'd0, PRN, 8'd7, LDI, 8'd0, 8'd0,
                 POP, 8'd1, PRN, 8'd1, PRN, 8'd7, HLT};
        load_prog();
        expect_out(8'hF3, "R6 R7 after push");
        expect_out(8'd5,  "R7 popped value");
        expect_out(8'hF4, "R7 R7 after pop");
        release_core();
        finish_prog("R6", 200, 1'b0);

        // R6 R7 R8: stack wraps through 0xFF and back to 0x00
        prog = '{LDI, 8'd7, 8'd0, LDI, 8'd0, 8'h5A, PSH, 8'd0, PRN, 8'd7,
                 POP, 8'd2, PRN, 8'd2, PRN, 8'd7, HLT};
        load_prog();
        expect_out(8'hFF, "R6 stack wraps down");
        expect_out(8'h5A, "R7 pop at 0xFF");
        expect_out(8'h00, "R7 stack wraps up");
        release_core();
        finish_prog("R7 wrap", 200, 1'b0);

        // R6: pushing R7 stores the decremented value; R7: pop into R7 adds one
        prog = '{LDI, 8'd7, 8'h80, PSH, 8'd7, POP, 8'd1, PRN, 8'd1,
                 LDI, 8'd0, 8'h40, PSH, 8'd0, POP, 8'd7, PRN, 8'd7, HLT};
        load_prog();
        expect_out(8'h7F, "R6 push of R7 stores new R7");
        expect_out(8'h41, "R7 pop into R7");
        release_core();
        finish_prog("R7 self", 200, 1'b0);

        // R2: load port toggled while running must not alter memory
        prog = '{LDI, 8'd3, 8'h11, PRN, 8'd3, HLT};
        load_prog();
        expect_out(8'h11, "R2 load port ignored when running");
        @(negedge clk);
        rst_n   = 1'b1;
        ld_en   = 1'b1;
        ld_addr = 8'd2;
        ld_data = 8'h99;
        repeat (2) @(negedge clk);
        ld_en = 1'b0;
        finish_prog("R2", 100, 1'b0);

        // R9: nothing after HLT executes
        prog = '{LDI, 8'd1, 8'h33, HLT, PRN, 8'd1, PRN, 8'd1};
        load_prog();
        release_core();
        finish_prog("R9", 100, 1'b0);

        // R10: undefined opcode halts with the illegal flag
        prog = '{PRN, 8'd0, 8'hFF, PRN, 8'd0, HLT};
        load_prog();
        expect_out(8'h00, "R10 print before bad opcode");
        release_core();
        finish_prog("R10", 100, 1'b1);

        // R10: zero opcode is also undefined
        prog = '{8'h00, PRN, 8'd0, HLT};
        load_prog();
        release_core();
        finish_prog("R10 zero", 100, 1'b1);

        // R1: flags clear again after reset
        chk(halted == 1'b0, "R1 halted cleared", int'(halted), 0);
        chk(illegal == 1'b0, "R1 illegal cleared", int'(illegal), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule